// File: doc/BRIEF.md
# Core Launch Request Decoder

This block sits between the cores and the core-control logic. It decodes hub-operation instructions that ask for a core to be started. An instruction arrives with two flag bits, the issuer's core number and two full 32-bit operand values. The immediate flag separates launches from every other hub operation. Operations that are not launches are forwarded unchanged. Within a launch, the result flag selects one of two actions: start the lowest-numbered idle core, or restart the issuing core. No operand bits are spent on a target number. The source operand becomes a long-aligned start address and the destination operand becomes the parameter word, both full width.

The block keeps a busy mask with one bit per core. A chosen target is offered to the core-control side on a request channel that holds until it is accepted. On acceptance the target is marked busy, and the issuer receives a result value and carry. One cycle after acceptance the parameter word is presented to the target. If a start-any request finds every core busy, it fails at once with carry set, and no request is made. Core-control reports stopped cores on a separate input, which frees their bits.

Top module: `core_launch_decoder`

## Requirements
- R1: After reset, op_ready is 1; req_valid, res_valid, other_valid and param_valid are 0; core_busy equals the RESET_BUSY parameter (default 8'h01).
- R2: An accepted op with op_imm=0 raises other_valid for one cycle on the next cycle, with other_src/other_dst equal to the operands. No request or result is produced, and core_busy is unchanged.
- R3: An accepted op with op_imm=1 and op_res=1, while some core is idle, raises req_valid on the next cycle with req_core equal to the lowest-numbered core whose core_busy bit is 0.
- R4: req_addr equals op_src with bits [1:0] forced to 0, and req_param equals op_dst with all 32 bits intact.
- R5: An accepted op with op_imm=1 and op_res=0 requests the issuing core (req_core = op_core), whatever its busy bit. On acceptance the result is op_core with carry 0.
- R6: An op with op_imm=1 and op_res=1 while all core_busy bits are 1 gives, on the next cycle, res_valid=1, res_carry=1 and res_value=NCORES-1 (7). req_valid stays 0.
- R7: While req_valid=1 and req_ready=0, req_valid, req_core, req_addr and req_param hold their values and op_ready is 0.
- R8: At the edge where req_valid and req_ready are both 1, the core_busy bit of req_core is set. After that edge, res_valid=1 for one cycle, with res_carry=0 and res_value=req_core.
- R9: On the cycle after acceptance, param_valid=1 for one cycle, with param_core and param_value equal to the accepted req_core and req_param.
- R10: A stop_valid pulse clears the core_busy bit of stop_id at the next edge. If that same core is being set by an acceptance at the same edge, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Hub operation presented |
| op_ready | output | 1 | Decoder can accept an operation |
| op_imm | input | 1 | 1 = launch, 0 = other hub operation |
| op_res | input | 1 | 1 = start any idle core, 0 = restart issuer |
| op_core | input | 3 | Issuing core number |
| op_src | input | 32 | Source operand (start address) |
| op_dst | input | 32 | Destination operand (parameter word) |
| other_valid | output | 1 | Forwarded non-launch operation pulse |
| other_src | output | 32 | Forwarded source operand |
| other_dst | output | 32 | Forwarded destination operand |
| req_valid | output | 1 | Launch request pending |
| req_ready | input | 1 | Core control accepts the request |
| req_core | output | 3 | Target core |
| req_addr | output | 32 | Long-aligned start address |
| req_param | output | 32 | Parameter word |
| param_valid | output | 1 | Parameter delivery pulse |
| param_core | output | 3 | Core receiving the parameter |
| param_value | output | 32 | Parameter word delivered |
| res_valid | output | 1 | Result to issuer |
| res_value | output | 32 | Core number, or 7 on failure |
| res_carry | output | 1 | 1 = no idle core |
| stop_valid | input | 1 | A core has stopped |
| stop_id | input | 3 | Stopped core number |
| core_busy | output | 8 | Busy mask, bit n = core n running |

## Verification
Three outputs appear one edge after an op is accepted: the forwarded operation, the launch request, and the failure result. The success result and the parameter delivery appear one edge after the accepting req_ready edge. Busy-mask changes from acceptance or stop also appear after that single edge. The bench changes inputs on falling edges and reads outputs on the next falling edge after the edge that registers them, so each check lands exactly one cycle after its cause. The sweep sets every one of the 256 busy masks by restarting chosen cores. For each mask it issues a start-any launch and works out the expected target, or the failure, from the lowest zero bit. It also varies the accept delay and checks that the request holds while it waits.

// File: rtl/clr_pkg.sv
// Package: shared constants and state type for the core launch decoder.
// Assumes a power-of-two core count no larger than 256.
package clr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,   // ready for a new hub operation
        ST_REQ  = 1'b1    // launch request waiting for acceptance
    } clr_state_e;
endpackage

// File: rtl/clr_free_pick.sv
// Module: lowest-idle-core finder.
// Takes the busy mask and returns the index of the lowest zero bit plus a
// flag saying whether any zero bit exists. Purely combinational apart from
// the clocked check, which needs clk and rst_n.
module clr_free_pick #(
    parameter int NCORES = 8,
    localparam int CW = $clog2(NCORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] busy,
    output logic              any_free,
    output logic [CW-1:0]     pick
);
    logic [NCORES-1:0] first_free;

    // one-hot marker of the lowest idle core, one cell per core
    genvar gi;
    generate
        for (gi = 0; gi < NCORES; gi++) begin : g_first
            if (gi == 0) begin : g_lo
                assign first_free[gi] = ~busy[gi];
            end else begin : g_hi
                assign first_free[gi] = ~busy[gi] & (&busy[gi-1:0]);
            end
        end
    endgenerate

    // encode the one-hot marker into a core index
    always_comb begin
        pick = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (first_free[i]) pick = CW'(i);
        end
        any_free = |first_free;
    end

    // R3: the chosen core is idle and every lower core is busy
    a_r3_pick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> (!busy[pick] && ((busy & ((NCORES'(1) << pick) - NCORES'(1)))
                                      == ((NCORES'(1) << pick) - NCORES'(1)))));
    // R6: with nothing idle, the marker is empty
    a_r6_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !any_free);
endmodule

// File: rtl/clr_busy_track.sv
// Module: busy-mask register.
// Sets one bit per accepted launch and clears one bit per stop report.
// Assumes at most one set and one clear per cycle; a set beats a clear
// aimed at the same core in the same cycle.
module clr_busy_track #(
    parameter int                NCORES     = 8,
    parameter logic [NCORES-1:0] RESET_BUSY = 8'h01,
    localparam int CW = $clog2(NCORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [CW-1:0]     set_id,
    input  logic              clr_en,
    input  logic [CW-1:0]     clr_id,
    output logic [NCORES-1:0] busy
);
    logic [NCORES-1:0] set_vec;
    logic [NCORES-1:0] clr_vec;

    // decode set and clear requests into per-core vectors
    always_comb begin
        set_vec = set_en ? (NCORES'(1) << set_id) : '0;
        clr_vec = clr_en ? (NCORES'(1) << clr_id) : '0;
    end

    // hold the mask: clear first, then set so that a set wins
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= RESET_BUSY;
        else        busy <= (busy & ~clr_vec) | set_vec;
    end

    // R10: a set lands regardless of a clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> busy[$past(set_id)]);
    // R10: a clear with no matching set empties the bit
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_id == clr_id)) |=> !busy[$past(clr_id)]);
endmodule

// File: rtl/core_launch_decoder.sv
// Module: core launch request decoder (top).
// Decodes hub operations. Non-launch operations are forwarded. Launches
// target the lowest idle core or the issuing core, with a long-aligned
// start address and a full-width parameter. One request is in flight at a
// time; op_ready is low while it waits. Assumes core control reports
// stopped cores on stop_valid/stop_id.
module core_launch_decoder #(
    parameter int                NCORES     = 8,
    parameter int                DW         = 32,
    parameter int                ALIGN_BITS = 2,
    parameter logic [NCORES-1:0] RESET_BUSY = 8'h01,
    localparam int CW = $clog2(NCORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_imm,
    input  logic              op_res,
    input  logic [CW-1:0]     op_core,
    input  logic [DW-1:0]     op_src,
    input  logic [DW-1:0]     op_dst,
    output logic              other_valid,
    output logic [DW-1:0]     other_src,
    output logic [DW-1:0]     other_dst,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CW-1:0]     req_core,
    output logic [DW-1:0]     req_addr,
    output logic [DW-1:0]     req_param,
    output logic              param_valid,
    output logic [CW-1:0]     param_core,
    output logic [DW-1:0]     param_value,
    output logic              res_valid,
    output logic [DW-1:0]     res_value,
    output logic              res_carry,
    input  logic              stop_valid,
    input  logic [CW-1:0]     stop_id,
    output logic [NCORES-1:0] core_busy
);
    import clr_pkg::*;

    localparam logic [DW-1:0] ALIGN_MASK = ~((DW'(1) << ALIGN_BITS) - DW'(1));
    localparam logic [DW-1:0] FAIL_VALUE = DW'(NCORES - 1);

    clr_state_e    state;
    logic          any_free;
    logic [CW-1:0] free_id;
    logic          take_op;
    logic          accept;

    clr_free_pick #(.NCORES(NCORES)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (core_busy),
        .any_free (any_free),
        .pick     (free_id)
    );

    clr_busy_track #(.NCORES(NCORES), .RESET_BUSY(RESET_BUSY)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (accept),
        .set_id (req_core),
        .clr_en (stop_valid),
        .clr_id (stop_id),
        .busy   (core_busy)
    );

    // handshake qualifiers for incoming ops and outgoing requests
    always_comb begin
        op_ready = (state == ST_IDLE);
        take_op  = op_valid && op_ready;
        accept   = req_valid && req_ready;
    end

    // decode ops, hold requests, and emit result and parameter pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            other_valid <= 1'b0;
            other_src   <= '0;
            other_dst   <= '0;
            req_valid   <= 1'b0;
            req_core    <= '0;
            req_addr    <= '0;
            req_param   <= '0;
            param_valid <= 1'b0;
            param_core  <= '0;
            param_value <= '0;
            res_valid   <= 1'b0;
            res_value   <= '0;
            res_carry   <= 1'b0;
        end else begin
            other_valid <= 1'b0;
            param_valid <= 1'b0;
            res_valid   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take_op) begin
                        if (!op_imm) begin
                            other_valid <= 1'b1;
                            other_src   <= op_src;
                            other_dst   <= op_dst;
                        end else if (op_res && !any_free) begin
                            res_valid <= 1'b1;
                            res_value <= FAIL_VALUE;
                            res_carry <= 1'b1;
                        end else begin
                            req_valid <= 1'b1;
                            req_core  <= op_res ? free_id : op_core;
                            req_addr  <= op_src & ALIGN_MASK;
                            req_param <= op_dst;
                            state     <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (accept) begin
                        req_valid   <= 1'b0;
                        res_valid   <= 1'b1;
                        res_value   <= DW'(req_core);
                        res_carry   <= 1'b0;
                        param_valid <= 1'b1;
                        param_core  <= req_core;
                        param_value <= req_param;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: a waiting request holds its contents and blocks new ops
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && !op_ready && $stable(req_core)
                                       && $stable(req_addr) && $stable(req_param)));
    // R4: start addresses are always long aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[ALIGN_BITS-1:0] == '0));
    // R8: acceptance marks the target busy and reports it without carry
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (core_busy[$past(req_core)] && res_valid && !res_carry
                    && res_value == DW'($past(req_core))));
    // R9: parameter pulse follows acceptance with the accepted word
    a_r9_param: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (param_valid && param_value == $past(req_param)
                    && param_core == $past(req_core)));
    // R6: a carried result always carries the failure value
    a_r6_fail_value: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_carry) |-> (res_value == FAIL_VALUE && !param_valid));
    // R2: a forwarded operation never coincides with a new request
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        other_valid |-> (!res_valid && !param_valid && !$rose(req_valid)));
endmodule

// File: tb/core_launch_decoder_test.sv
// Bench: sweeps all busy masks, checks targets, failures, forwarding,
// alignment, hold under back-pressure and the set-beats-stop case.
module core_launch_decoder_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_imm = 1'b0, op_res = 1'b0;
    logic [2:0]  op_core = '0;
    logic [31:0] op_src = '0, op_dst = '0;
    logic        req_ready = 1'b0, stop_valid = 1'b0;
    logic [2:0]  stop_id = '0;
    logic        op_ready, other_valid, req_valid, param_valid, res_valid, res_carry;
    logic [31:0] other_src, other_dst, req_addr, req_param, param_value, res_value;
    logic [2:0]  req_core, param_core;
    logic [7:0]  core_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    core_launch_decoder uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_imm(op_imm), .op_res(op_res), .op_core(op_core),
        .op_src(op_src), .op_dst(op_dst),
        .other_valid(other_valid), .other_src(other_src), .other_dst(other_dst),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_addr(req_addr), .req_param(req_param),
        .param_valid(param_valid), .param_core(param_core), .param_value(param_value),
        .res_valid(res_valid), .res_value(res_value), .res_carry(res_carry),
        .stop_valid(stop_valid), .stop_id(stop_id), .core_busy(core_busy)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // present one op for one edge; returns at the next falling edge
    task automatic issue(input bit imm, input bit res, input logic [2:0] id,
                         input logic [31:0] s, input logic [31:0] d);
        op_valid = 1'b1; op_imm = imm; op_res = res; op_core = id;
        op_src = s; op_dst = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // accept the pending request at the next edge
    task automatic take(input bit with_stop, input logic [2:0] sid);
        req_ready = 1'b1; stop_valid = with_stop; stop_id = sid;
        @(negedge clk);
        req_ready = 1'b0; stop_valid = 1'b0;
    endtask

    task automatic stop_core(input logic [2:0] sid);
        stop_valid = 1'b1; stop_id = sid;
        @(negedge clk);
        stop_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk(op_ready && !req_valid && !res_valid && !other_valid && !param_valid,
            "R1 idle outputs", {op_ready, req_valid, res_valid, other_valid}, 4'b1000);
        chk(core_busy == 8'h01, "R1 busy reset", core_busy, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: forwarding leaves everything else untouched
        for (int k = 0; k < 4; k++) begin
            logic [31:0] s, d;
            s = 32'hA5A5_0003 + 32'(k * 7919);
            d = 32'h1234_5678 ^ 32'(k << 9);
            issue(1'b0, k[0], 3'(k), s, d);
            chk(other_valid && other_src == s && other_dst == d, "R2 forward",
                other_src, s);
            chk(!req_valid && !res_valid && core_busy == 8'h01, "R2 no side effect",
                {req_valid, res_valid}, 0);
            @(negedge clk);
            chk(!other_valid, "R2 single pulse", other_valid, 0);
        end

        // sweep every busy mask
        for (int m = 0; m < 256; m++) begin
            int exp_id;
            logic [31:0] s, d;
            for (int c = 0; c < 8; c++) stop_core(3'(c));
            chk(core_busy == 8'h00, "R10 all stopped", core_busy, 0);
            for (int c = 0; c < 8; c++) begin
                if (m[c]) begin
                    issue(1'b1, 1'b0, 3'(c), 32'h100 + 32'(c), 32'(m));
                    chk(req_valid && req_core == 3'(c), "R5 reload target", req_core, c);
                    take(1'b0, 3'd0);
                    chk(res_valid && !res_carry && res_value == 32'(c), "R5 reload result",
                        res_value, c);
                end
            end
            chk(core_busy == 8'(m), "R8 mask built", core_busy, m);
            exp_id = -1;
            for (int c = 7; c >= 0; c--) if (!m[c]) exp_id = c;
            s = 32'h8000_0000 + 32'(m * 4099);
            d = ~32'(m * 257);
            issue(1'b1, 1'b1, 3'(m % 8), s, d);
            if (exp_id < 0) begin
                // R6: nothing idle
                chk(res_valid && res_carry && res_value == 32'd7, "R6 fail result",
                    res_value, 7);
                chk(!req_valid && op_ready, "R6 no request", req_valid, 0);
                @(negedge clk);
                chk(!res_valid && core_busy == 8'hFF, "R6 mask kept", core_busy, 8'hFF);
            end else begin
                chk(req_valid && req_core == 3'(exp_id), "R3 lowest idle", req_core, exp_id);
                chk(req_addr == (s & 32'hFFFF_FFFC) && req_param == d, "R4 addr/param",
                    req_addr, s & 32'hFFFF_FFFC);
                chk(!res_valid, "R8 no early result", res_valid, 0);
                for (int w = 0; w < m % 3; w++) begin
                    @(negedge clk);
                    chk(req_valid && !op_ready && req_core == 3'(exp_id) &&
                        req_addr == (s & 32'hFFFF_FFFC) && req_param == d,
                        "R7 hold", req_core, exp_id);
                end
                take(1'b0, 3'd0);
                chk(res_valid && !res_carry && res_value == 32'(exp_id), "R8 result",
                    res_value, exp_id);
                chk(core_busy == (8'(m) | (8'd1 << exp_id)), "R8 busy set", core_busy,
                    8'(m) | (8'd1 << exp_id));
                chk(param_valid && param_core == 3'(exp_id) && param_value == d,
                    "R9 param", param_value, d);
                chk(!req_valid && op_ready, "R7 released", req_valid, 0);
                @(negedge clk);
                chk(!param_valid && !res_valid, "R9 single pulse", param_valid, 0);
            end
        end

        // R10: set and stop of the same core at one edge -> stays busy
        stop_core(3'd5);
        issue(1'b1, 1'b0, 3'd5, 32'h0000_0FFF, 32'hDEAD_BEEF);
        chk(req_addr == 32'h0000_0FFC, "R4 low bits cleared", req_addr, 32'hFFC);
        take(1'b1, 3'd5);
        chk(core_busy[5] == 1'b1, "R10 set beats stop", core_busy[5], 1);
        stop_core(3'd5);
        chk(core_busy[5] == 1'b0, "R10 stop clears", core_busy[5], 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule